// File: doc/BRIEF.md
# Change-Triggered Spawn Request Generator

This block sits at the commit stage of a processor core and turns committed triggering stores into requests to start helper threads. Each store event brings the word that was in memory before the store, the word being written, a byte-enable mask, the effective address and the base-register value. It also brings a flag that selects the argument mode, a link index taken from the spawn-link instruction that follows the store, and the current stack and global pointers. A helper thread is requested only when at least one enabled byte actually changes. A store that leaves memory as it was costs nothing downstream.

Spawn targets come from a small registry of up to `DEPTH` slots. The registry is filled at start-up through a configuration write port and stays fixed while the program runs. Each slot holds three program counters: where the helper thread begins, where the skippable region begins in the main thread, and where the main thread resumes after skipping that region. For a changing store that names a loaded slot, the block pushes a request carrying the helper start PC and three live-ins into a downstream queue. In the same cycle it tells the thread status table to allocate or refresh the slot's entry with both region PCs and mark it as spawning. If the queue is full, the status table is told to invalidate the entry instead, so that the main thread runs the region in place.

Top module: `chg_spawn_gen`

## Requirements
- R1: After reset, `q_push`, `tbl_upd`, `tbl_inval` and `err_flag` are all 0.
- R2: A store with `st_valid`=1 in which at least one enabled byte of `st_new` differs from `st_old` names a loaded slot while `q_full`=0. One cycle later `q_push` and `tbl_upd` are 1 for exactly that cycle, and `tbl_inval` is 0.
- R3: A store in which every enabled byte is unchanged produces no `q_push`, no `tbl_upd` and no `tbl_inval` one cycle later. Its link index is ignored, so it does not set `err_flag` even when the index is invalid.
- R4: Byte k of the data, bits [8k+7:8k], is compared only when `st_be[k]`=1. A difference confined to bytes that are not enabled counts as a silent store.
- R5: On a push, `q_arg` equals `st_addr` when `st_field_mode`=0 (per-variable mode) and `st_base` when `st_field_mode`=1 (per-field mode).
- R6: On a push, `q_sp` and `q_gp` equal the `st_sp` and `st_gp` of the triggering store.
- R7: On a push, `q_thread_pc` is the slot's helper start PC. `tbl_region_pc` and `tbl_resume_pc` are the slot's region start PC and resume PC. `tbl_slot` is the link index.
- R8: A changing store to a loaded slot while `q_full`=1 gives `q_push`=0, `tbl_upd`=0 and `tbl_inval`=1 one cycle later, with `tbl_slot` set to the link index.
- R9: A changing store whose link index is `DEPTH` or more, or names a slot never written, gives no push, update or invalidate. It sets `err_flag`, which stays at 1 until reset.
- R10: A configuration write (`cfg_we`=1) loads all three PCs of slot `cfg_idx` and marks that slot loaded. Writes with `cfg_idx` of `DEPTH` or more are ignored. A store looked up in the same cycle as a write to its slot sees the slot's contents from before the write.
- R11: `q_push` and `tbl_upd` are always equal, and `q_push` and `tbl_inval` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Registry slot write strobe |
| cfg_idx | input | IDX_W | Registry slot to write |
| cfg_thread_pc | input | PC_W | Helper thread start PC to store |
| cfg_region_pc | input | PC_W | Skippable region start PC to store |
| cfg_resume_pc | input | PC_W | Main-thread resume PC to store |
| st_valid | input | 1 | Committed triggering store present |
| st_old | input | DATA_W | Memory word before the store |
| st_new | input | DATA_W | Word being written |
| st_be | input | DATA_W/8 | Byte enables of the store |
| st_addr | input | ADDR_W | Effective address |
| st_base | input | ADDR_W | Base-register value |
| st_field_mode | input | 1 | 1 = pass base, 0 = pass effective address |
| st_link_idx | input | IDX_W | Registry index from the spawn-link instruction |
| st_sp | input | ADDR_W | Stack pointer live-in |
| st_gp | input | ADDR_W | Global pointer live-in |
| q_full | input | 1 | Downstream spawn queue cannot accept |
| q_push | output | 1 | Enqueue strobe |
| q_thread_pc | output | PC_W | Helper start PC of the request |
| q_arg | output | ADDR_W | Trigger argument of the request |
| q_sp | output | ADDR_W | Stack pointer of the request |
| q_gp | output | ADDR_W | Global pointer of the request |
| tbl_upd | output | 1 | Status table allocate/update to spawning |
| tbl_inval | output | 1 | Status table invalidate |
| tbl_slot | output | SLOT_W | Status table entry index |
| tbl_region_pc | output | PC_W | Region start PC for the table |
| tbl_resume_pc | output | PC_W | Resume PC for the table |
| err_flag | output | 1 | Sticky invalid-index flag |

## Verification
A registry slot can be written in the same cycle that a committed store looks up that slot. The bench forces this case on purpose. It rewrites a loaded slot with new PCs while a changing store names it, and expects the request to carry the old PCs and the following store to carry the new ones. It also writes a slot that was never loaded in the same cycle that a changing store names it, and expects the store to be dropped with the error flag set. Random traffic adds more overlaps of this kind, with configuration writes arriving at random, and a reference model in the bench applies each write only after that cycle's lookup.

// File: rtl/chg_spawn_pkg.sv
package chg_spawn_pkg;
   // Per-store outcome decided in the commit cycle
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_SPAWN = 2'd1,
      ACT_INVAL = 2'd2,
      ACT_DROP  = 2'd3
   } spawn_act_e;
endpackage

// File: rtl/cs_change_detect.sv
module cs_change_detect #(
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [BE_W-1:0]   be,
   output logic              changed
);
   logic [BE_W-1:0] byte_diff;

   for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign byte_diff[b] = be[b] && (old_word[8*b +: 8] != new_word[8*b +: 8]);
   end

   assign changed = |byte_diff;
endmodule

// File: rtl/cs_registry.sv
module cs_registry #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 3,
   parameter int PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PC_W-1:0]  wr_thread,
   input  logic [PC_W-1:0]  wr_region,
   input  logic [PC_W-1:0]  wr_resume,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hit,
   output logic [PC_W-1:0]  rd_thread,
   output logic [PC_W-1:0]  rd_region,
   output logic [PC_W-1:0]  rd_resume
);
   logic [DEPTH-1:0] loaded_q;
   logic [PC_W-1:0]  thread_q [DEPTH];
   logic [PC_W-1:0]  region_q [DEPTH];
   logic [PC_W-1:0]  resume_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            loaded_q[s] <= 1'b0;
            thread_q[s] <= '0;
            region_q[s] <= '0;
            resume_q[s] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(s))) begin
            loaded_q[s] <= 1'b1;
            thread_q[s] <= wr_thread;
            region_q[s] <= wr_region;
            resume_q[s] <= wr_resume;
         end
      end
   end

   // Read sees registered contents: a same-cycle write lands afterwards
   always_comb begin
      rd_hit    = 1'b0;
      rd_thread = '0;
      rd_region = '0;
      rd_resume = '0;
      for (int s = 0; s < DEPTH; s++) begin
         if (rd_idx == IDX_W'(s)) begin
            rd_hit    = loaded_q[s];
            rd_thread = thread_q[s];
            rd_region = region_q[s];
            rd_resume = resume_q[s];
         end
      end
   end
endmodule

// File: rtl/chg_spawn_gen.sv
module chg_spawn_gen
   import chg_spawn_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32,
   parameter int DEPTH  = 4,
   parameter int IDX_W  = 3,
   localparam int BE_W   = DATA_W / 8,
   localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [PC_W-1:0]   cfg_thread_pc,
   input  logic [PC_W-1:0]   cfg_region_pc,
   input  logic [PC_W-1:0]   cfg_resume_pc,
   input  logic              st_valid,
   input  logic [DATA_W-1:0] st_old,
   input  logic [DATA_W-1:0] st_new,
   input  logic [BE_W-1:0]   st_be,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [ADDR_W-1:0] st_base,
   input  logic              st_field_mode,
   input  logic [IDX_W-1:0]  st_link_idx,
   input  logic [ADDR_W-1:0] st_sp,
   input  logic [ADDR_W-1:0] st_gp,
   input  logic              q_full,
   output logic              q_push,
   output logic [PC_W-1:0]   q_thread_pc,
   output logic [ADDR_W-1:0] q_arg,
   output logic [ADDR_W-1:0] q_sp,
   output logic [ADDR_W-1:0] q_gp,
   output logic              tbl_upd,
   output logic              tbl_inval,
   output logic [SLOT_W-1:0] tbl_slot,
   output logic [PC_W-1:0]   tbl_region_pc,
   output logic [PC_W-1:0]   tbl_resume_pc,
   output logic              err_flag
);
   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a positive multiple of 8");
   end
   if (DEPTH < 1 || DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("DEPTH must be between 1 and 2**IDX_W");
   end
   if (SLOT_W > IDX_W) begin : g_bad_slot
      $error("IDX_W too narrow for DEPTH");
   end

   logic             changed;
   logic             slot_hit;
   logic [PC_W-1:0]  ent_thread, ent_region, ent_resume;
   logic [ADDR_W-1:0] trig_arg;
   spawn_act_e       act;

   cs_change_detect #(.DATA_W(DATA_W)) u_cmp (
      .old_word (st_old),
      .new_word (st_new),
      .be       (st_be),
      .changed  (changed)
   );

   cs_registry #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PC_W(PC_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_idx    (cfg_idx),
      .wr_thread (cfg_thread_pc),
      .wr_region (cfg_region_pc),
      .wr_resume (cfg_resume_pc),
      .rd_idx    (st_link_idx),
      .rd_hit    (slot_hit),
      .rd_thread (ent_thread),
      .rd_region (ent_region),
      .rd_resume (ent_resume)
   );

   assign trig_arg = st_field_mode ? st_base : st_addr;

   always_comb begin
      act = ACT_NONE;
      if (st_valid && changed) begin
         if (!slot_hit)   act = ACT_DROP;
         else if (q_full) act = ACT_INVAL;
         else             act = ACT_SPAWN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_push    <= 1'b0;
         tbl_upd   <= 1'b0;
         tbl_inval <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         q_push    <= (act == ACT_SPAWN);
         tbl_upd   <= (act == ACT_SPAWN);
         tbl_inval <= (act == ACT_INVAL);
         if (act == ACT_DROP) err_flag <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_thread_pc   <= '0;
         q_arg         <= '0;
         q_sp          <= '0;
         q_gp          <= '0;
         tbl_slot      <= '0;
         tbl_region_pc <= '0;
         tbl_resume_pc <= '0;
      end else if (st_valid) begin
         q_thread_pc   <= ent_thread;
         q_arg         <= trig_arg;
         q_sp          <= st_sp;
         q_gp          <= st_gp;
         tbl_slot      <= st_link_idx[SLOT_W-1:0];
         tbl_region_pc <= ent_region;
         tbl_resume_pc <= ent_resume;
      end
   end
endmodule

// File: rtl/chg_spawn_chk.sv
module chg_spawn_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic [DATA_W-1:0] st_old,
   input logic [DATA_W-1:0] st_new,
   input logic              st_field_mode,
   input logic [ADDR_W-1:0] st_addr,
   input logic [ADDR_W-1:0] st_base,
   input logic [ADDR_W-1:0] st_sp,
   input logic              q_full,
   input logic              q_push,
   input logic [ADDR_W-1:0] q_arg,
   input logic [ADDR_W-1:0] q_sp,
   input logic              tbl_upd,
   input logic              tbl_inval,
   input logic              err_flag
);
   p_push_upd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      q_push == tbl_upd);
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_push && tbl_inval));
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |=> (!q_push && !tbl_inval));
   p_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_old == st_new) |=> (!q_push && !tbl_inval));
   p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && q_full) |=> !q_push);
   p_arg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !q_full) |=>
         (!q_push || q_arg == ($past(st_field_mode) ? $past(st_base) : $past(st_addr))));
   p_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |=> (!q_push || q_sp == $past(st_sp)));
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
endmodule

bind chg_spawn_gen chg_spawn_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/chg_spawn_gen_bench.sv
module chg_spawn_gen_bench;
   localparam int DW = 32, AW = 32, PW = 32, DEP = 4, IW = 3, BW = DW / 8, SW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [PW-1:0] cfg_thread_pc = '0, cfg_region_pc = '0, cfg_resume_pc = '0;
   logic st_valid = 1'b0;
   logic [DW-1:0] st_old = '0, st_new = '0;
   logic [BW-1:0] st_be = '0;
   logic [AW-1:0] st_addr = '0, st_base = '0, st_sp = '0, st_gp = '0;
   logic st_field_mode = 1'b0;
   logic [IW-1:0] st_link_idx = '0;
   logic q_full = 1'b0;
   logic q_push, tbl_upd, tbl_inval, err_flag;
   logic [PW-1:0] q_thread_pc, tbl_region_pc, tbl_resume_pc;
   logic [AW-1:0] q_arg, q_sp, q_gp;
   logic [SW-1:0] tbl_slot;

   always #5 clk = ~clk;

   chg_spawn_gen #(.DATA_W(DW), .ADDR_W(AW), .PC_W(PW), .DEPTH(DEP), .IDX_W(IW)) u_chg_spawn_gen (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Reference model state
   bit        m_ld [8];
   logic [PW-1:0] m_thr [8], m_rgn [8], m_res [8];
   bit        m_err = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit diff_f(logic [DW-1:0] o, logic [DW-1:0] n, logic [BW-1:0] be);
      bit d = 1'b0;
      for (int b = 0; b < BW; b++) if (be[b] && o[8*b +: 8] != n[8*b +: 8]) d = 1'b1;
      return d;
   endfunction

   // One cycle: drive at negedge, check outputs at next negedge
   task automatic step(bit sv, logic [DW-1:0] o, logic [DW-1:0] n, logic [BW-1:0] be,
                       logic [AW-1:0] ad, logic [AW-1:0] bs, bit fm, logic [IW-1:0] ix,
                       logic [AW-1:0] sp, logic [AW-1:0] gp, bit full,
                       bit we, logic [IW-1:0] wi, logic [PW-1:0] wt, logic [PW-1:0] wr, logic [PW-1:0] ws);
      bit e_push = 0, e_inval = 0;
      logic [PW-1:0] e_thr = '0, e_rgn = '0, e_res = '0;
      st_valid = sv; st_old = o; st_new = n; st_be = be; st_addr = ad; st_base = bs;
      st_field_mode = fm; st_link_idx = ix; st_sp = sp; st_gp = gp; q_full = full;
      cfg_we = we; cfg_idx = wi; cfg_thread_pc = wt; cfg_region_pc = wr; cfg_resume_pc = ws;
      if (sv && diff_f(o, n, be)) begin
         if (!(ix < DEP && m_ld[ix])) m_err = 1'b1;
         else if (full) e_inval = 1'b1;
         else begin e_push = 1'b1; e_thr = m_thr[ix]; e_rgn = m_rgn[ix]; e_res = m_res[ix]; end
      end
      if (we && wi < DEP) begin m_ld[wi] = 1'b1; m_thr[wi] = wt; m_rgn[wi] = wr; m_res[wi] = ws; end
      @(negedge clk);
      chk("R2 push", 64'(q_push), 64'(e_push));
      chk("R11 upd", 64'(tbl_upd), 64'(e_push));
      chk("R8 inval", 64'(tbl_inval), 64'(e_inval));
      chk("R9 err", 64'(err_flag), 64'(m_err));
      if (e_push) begin
         chk("R5 arg", 64'(q_arg), 64'(fm ? bs : ad));
         chk("R6 sp", 64'(q_sp), 64'(sp));
         chk("R6 gp", 64'(q_gp), 64'(gp));
         chk("R7 thread", 64'(q_thread_pc), 64'(e_thr));
         chk("R7 region", 64'(tbl_region_pc), 64'(e_rgn));
         chk("R7 resume", 64'(tbl_resume_pc), 64'(e_res));
      end
      if (e_push || e_inval) chk("R7 slot", 64'(tbl_slot), 64'(ix[SW-1:0]));
   endtask

   task automatic cfg(logic [IW-1:0] wi, logic [PW-1:0] t, logic [PW-1:0] r, logic [PW-1:0] s);
      step(0, '0, '0, '0, '0, '0, 0, '0, '0, '0, 0, 1, wi, t, r, s);
   endtask

   task automatic st(logic [DW-1:0] o, logic [DW-1:0] n, logic [BW-1:0] be, bit fm,
                     logic [IW-1:0] ix, bit full);
      step(1, o, n, be, 32'hA000_0010, 32'hB000_0000, fm, ix, 32'h7FFF_F000, 32'h1000_8000,
           full, 0, '0, '0, '0, '0);
   endtask

   initial begin
      int unsigned seed = 32'd1357;
      void'($urandom(seed));
      for (int i = 0; i < 8; i++) begin m_ld[i] = 0; m_thr[i] = '0; m_rgn[i] = '0; m_res[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 push", 64'(q_push), 0);
      chk("R1 upd", 64'(tbl_upd), 0);
      chk("R1 inval", 64'(tbl_inval), 0);
      chk("R1 err", 64'(err_flag), 0);
      // R3: silent store with an invalid index is ignored, no error
      st(32'h1234_5678, 32'h1234_5678, 4'hF, 0, 3'd6, 0);
      // R10: load slots 0..2, slot 3 left unloaded; write beyond DEPTH ignored
      cfg(3'd0, 32'h0000_1000, 32'h0000_2000, 32'h0000_2100);
      cfg(3'd1, 32'h0000_3000, 32'h0000_4000, 32'h0000_4100);
      cfg(3'd2, 32'h0000_5000, 32'h0000_6000, 32'h0000_6100);
      cfg(3'd5, 32'hDEAD_0000, 32'hDEAD_0001, 32'hDEAD_0002);
      // R2/R5: per-variable and per-field modes
      st(32'h0, 32'h1, 4'h1, 0, 3'd0, 0);
      st(32'h0, 32'h0100_0000, 4'h8, 1, 3'd2, 0);
      // R4: difference only in disabled byte is silent
      st(32'h0000_0000, 32'h0000_FF00, 4'hD, 0, 3'd1, 0);
      // R8: queue full gives invalidate
      st(32'h5, 32'h6, 4'hF, 0, 3'd1, 1);
      // R10: same-cycle write and lookup of slot 1 uses old contents
      step(1, 32'h0, 32'h9, 4'hF, 32'hC0, 32'hD0, 0, 3'd1, 32'h11, 32'h22, 0,
           1, 3'd1, 32'h0000_7000, 32'h0000_8000, 32'h0000_8100);
      st(32'h0, 32'h9, 4'hF, 1, 3'd1, 0);
      // R9/R10: unloaded slot 3 written in same cycle -> dropped with error
      step(1, 32'h0, 32'h9, 4'hF, 32'hC0, 32'hD0, 0, 3'd3, 32'h11, 32'h22, 0,
           1, 3'd3, 32'h0000_9000, 32'h0000_A000, 32'h0000_A100);
      st(32'h0, 32'h2, 4'h3, 0, 3'd3, 0);
      // R9: out-of-range index
      st(32'h0, 32'h2, 4'h3, 0, 3'd7, 0);
      // Random traffic
      for (int k = 0; k < 400; k++) begin
         logic [DW-1:0] o = $urandom;
         logic [DW-1:0] n = ($urandom % 2) ? o : (o ^ (32'd1 << ($urandom % 32)));
         step($urandom % 4 != 0, o, n, 4'($urandom), $urandom, $urandom, $urandom % 2,
              IW'($urandom % 6), $urandom, $urandom, ($urandom % 4) == 0,
              ($urandom % 10) == 0, IW'($urandom % 5), $urandom, $urandom, $urandom);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule